// File: doc/BRIEF.md
# Per-Channel ADC Result Bank with Read-Captured High Bits

This block holds the latest 10-bit conversion result of each of eight analog channels and presents them to an 8-bit special-function-register bus. A conversion-complete strobe carries a channel index and a 10-bit value and overwrites that channel's stored result. Each channel's lower eight bits appear at their own read-only address. The upper two bits of every channel go through one shared high-bits register.

Reading a channel's low byte has a side effect. It copies that channel's upper two bits into the shared high-bits latch. Software reads the low byte first and the shared register second, and gets both halves of the same conversion even if new results arrive in between. The stored results are not cleared by reset. Only the shared latch is cleared.

Top module: `adc_result_bank`

## Requirements
- R1: A conversion strobe (`cv_valid`=1) stores `cv_data` for channel `cv_chan`. A read of address 86h + 10h·n (n = 0..7) returns bits 7..0 of channel n's stored result on `bus_rdata`.
- R2: A read of address F7h returns the shared high-bits latch in `bus_rdata` bits 1..0, where bit 1 is result bit 9 and bit 0 is result bit 8. Bits 7..2 read as zero.
- R3: At the clock edge that ends a low-byte read of channel n, the latch takes channel n's stored result bits 9..8.
- R4: Between low-byte reads, the latch keeps its value. This holds through new conversions, reads of F7h and accesses to any other address.
- R5: While `rst_n` is low, the latch is 00b. Stored results keep their values across a reset.
- R6: If a conversion for channel n and a low-byte read of channel n fall in the same cycle, the read data and the captured high bits both come from the previous result. The new result is readable from the next cycle.
- R7: A cycle with `bus_wr`=1 is ignored, whether or not `bus_rd` is also 1. In such a cycle:
  - no stored result changes;
  - the latch does not change;
  - `bus_hit`=0 and `bus_rdata`=00h.
- R8: `bus_hit` is 1 exactly when a read targets one of the nine decoded addresses. Any other read gives `bus_hit`=0 and `bus_rdata`=00h and leaves the latch unchanged.
- R9: Read data is combinational. It is valid in the same cycle as the read strobe and the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears only the shared latch |
| cv_valid | input | 1 | Conversion-complete strobe |
| cv_chan | input | 3 | Channel index of the completed conversion |
| cv_data | input | 10 | Completed 10-bit result |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (writes are ignored) |
| bus_rdata | output | 8 | Read data, zero when not selected |
| bus_hit | output | 1 | High when this block claims the current read |

## Verification
- **Same-cycle results.** `bus_rdata` and `bus_hit` are due in the cycle in which the strobe and address are driven. The bench drives inputs at the falling edge and compares them a few nanoseconds later, before the next rising edge.
- **Next-edge results.** Latch captures and stored conversions take effect at the following rising edge. The reference model commits its own state only after that edge, so the next cycle's comparison sees the updated state.
- **Same-cycle collision.** A combined conversion and read of one channel is checked against pre-edge model state in its own cycle, and against the new value in the next cycle.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LOW  = 2'd1,
      ACC_HIGH = 2'd2
   } acc_kind_e;

   // Low-byte register address of a given channel.
   function automatic int lowbyte_addr(input int base, input int stride, input int idx);
      return base + stride * idx;
   endfunction

endpackage

// File: rtl/adc_rb_decode.sv
module adc_rb_decode
   import adc_rb_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int ADDR_W     = 8,
   parameter int LOW_BASE   = 'h86,
   parameter int LOW_STRIDE = 'h10,
   parameter int HIGH_ADDR  = 'hF7,
   parameter int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output acc_kind_e         kind,
   output logic [CH_W-1:0]   ch
);

   localparam int LAST_LOW = LOW_BASE + LOW_STRIDE * (NUM_CH - 1);

   if (LAST_LOW >= (1 << ADDR_W)) begin : g_bad_range
      $error("low-byte addresses exceed the address space");
   end
   if (HIGH_ADDR >= (1 << ADDR_W)) begin : g_bad_high
      $error("high-bits address exceeds the address space");
   end

   logic [NUM_CH-1:0] low_hit;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_low
      localparam int ADDR_G = lowbyte_addr(LOW_BASE, LOW_STRIDE, g);
      if (ADDR_G == HIGH_ADDR) begin : g_clash
         $error("low-byte address collides with high-bits address");
      end
      assign low_hit[g] = (addr == ADDR_W'(ADDR_G));
   end

   logic rd_ok;
   assign rd_ok = rd & ~wr;

   always_comb begin
      ch = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (low_hit[i]) ch = ch | CH_W'(i);
      end
   end

   always_comb begin
      if (!rd_ok)                          kind = ACC_NONE;
      else if (|low_hit)                   kind = ACC_LOW;
      else if (addr == ADDR_W'(HIGH_ADDR)) kind = ACC_HIGH;
      else                                 kind = ACC_NONE;
   end

endmodule

// File: rtl/adc_rb_store.sv
module adc_rb_store #(
   parameter int NUM_CH = 8,
   parameter int RES_W  = 10,
   parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_ch,
   input  logic [RES_W-1:0] wr_data,
   input  logic [CH_W-1:0]  rd_ch,
   output logic [RES_W-1:0] rd_data
);

   logic [RES_W-1:0] cells [NUM_CH];

   // Result cells carry no reset: contents survive a chip reset.
   for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
      logic [RES_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_ch == CH_W'(g))) cell_q <= wr_data;
      end
      assign cells[g] = cell_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_ch == CH_W'(i)) rd_data = cells[i];
      end
   end

endmodule

// File: rtl/adc_rb_hilatch.sv
module adc_rb_hilatch #(
   parameter int HI_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_en,
   input  logic [HI_W-1:0] cap_bits,
   output logic [HI_W-1:0] hi_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_q <= '0;
      else if (cap_en) hi_q <= cap_bits;
   end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
   import adc_rb_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int RES_W      = 10,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter int LOW_BASE   = 'h86,
   parameter int LOW_STRIDE = 'h10,
   parameter int HIGH_ADDR  = 'hF7,
   parameter int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_valid,
   input  logic [CH_W-1:0]   cv_chan,
   input  logic [RES_W-1:0]  cv_data,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_hit
);

   localparam int HI_W = RES_W - DATA_W;

   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
      $error("result width must exceed the bus width by 1..DATA_W bits");
   end
   if (NUM_CH < 1) begin : g_bad_count
      $error("at least one channel required");
   end

   acc_kind_e        kind;
   logic [CH_W-1:0]  sel_ch;
   logic [RES_W-1:0] store_rd;
   logic [HI_W-1:0]  hi_q;

   adc_rb_decode #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LOW_BASE(LOW_BASE),
      .LOW_STRIDE(LOW_STRIDE), .HIGH_ADDR(HIGH_ADDR), .CH_W(CH_W)
   ) i_decode (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .kind(kind), .ch(sel_ch)
   );

   adc_rb_store #(
      .NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)
   ) i_store (
      .clk(clk), .wr_en(cv_valid), .wr_ch(cv_chan), .wr_data(cv_data),
      .rd_ch(sel_ch), .rd_data(store_rd)
   );

   adc_rb_hilatch #(
      .HI_W(HI_W)
   ) i_hilatch (
      .clk(clk), .rst_n(rst_n), .cap_en(kind == ACC_LOW),
      .cap_bits(store_rd[RES_W-1 -: HI_W]), .hi_q(hi_q)
   );

   always_comb begin
      unique case (kind)
         ACC_LOW:  bus_rdata = store_rd[DATA_W-1:0];
         ACC_HIGH: bus_rdata = DATA_W'(hi_q);
         default:  bus_rdata = '0;
      endcase
   end

   assign bus_hit = (kind != ACC_NONE);

endmodule

// File: rtl/adc_rb_checker.sv
module adc_rb_checker #(
   parameter int RES_W     = 10,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int HIGH_ADDR = 'hF7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_hit,
   input logic [RES_W-1:0]  store_rd,
   input logic [RES_W-DATA_W-1:0] hi_q
);

   localparam int HI_W = RES_W - DATA_W;

   logic low_rd;
   assign low_rd = bus_hit && (bus_addr != ADDR_W'(HIGH_ADDR));

   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      low_rd |=> hi_q == $past(store_rd[RES_W-1 -: HI_W]));

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !low_rd |=> $stable(hi_q));

   a_r2_high_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hit && bus_addr == ADDR_W'(HIGH_ADDR)) |->
         (bus_rdata[DATA_W-1:HI_W] == '0 && bus_rdata[HI_W-1:0] == hi_q));

   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_hit |-> bus_rdata == '0);

   a_r7_write_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> !bus_hit);

   a_r9_hit_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hit |-> bus_rd);

   a_r5_reset_clear: assert property (@(posedge clk)
      !rst_n |-> hi_q == '0);

endmodule

bind adc_result_bank adc_rb_checker #(
   .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HIGH_ADDR(HIGH_ADDR)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
   .store_rd(store_rd), .hi_q(hi_q)
);

// File: tb/test_adc_result_bank.sv
`timescale 1ns/1ps
module test_adc_result_bank;

   localparam int HALF = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cv_valid = 1'b0;
   logic [2:0] cv_chan = '0;
   logic [9:0] cv_data = '0;
   logic [7:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_rdata;
   logic       bus_hit;

   always #HALF clk = ~clk;

   adc_result_bank i_adc_result_bank (
      .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_chan(cv_chan),
      .cv_data(cv_data), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_hit(bus_hit)
   );

   int compared = 0;
   int mismatched = 0;
   int model_mem [8];
   int model_hi = 0;

   function automatic int low_chan_of(input int a);
      if ((a % 16) == 6 && (a / 16) >= 8 && (a / 16) <= 15) return (a / 16) - 8;
      return -1;
   endfunction

   task automatic step(input bit cv, input int ch, input int d, input int a,
                       input bit rd, input bit wr, input string rq);
      int lc;
      bit rd_ok;
      int exp_data;
      bit exp_hit;
      @(negedge clk);
      cv_valid = cv; cv_chan = 3'(ch); cv_data = 10'(d);
      bus_addr = 8'(a); bus_rd = rd; bus_wr = wr;
      #2;
      rd_ok = rd && !wr;
      lc = low_chan_of(a);
      exp_hit = 1'b0; exp_data = 0;
      if (rd_ok && lc >= 0) begin
         exp_hit = 1'b1; exp_data = model_mem[lc] % 256;
      end else if (rd_ok && a == 'hF7) begin
         exp_hit = 1'b1; exp_data = model_hi;
      end
      compared++;
      if (bus_hit !== exp_hit || int'(bus_rdata) != exp_data || $isunknown(bus_rdata)) begin
         mismatched++;
         $display("FAIL %s addr=%02h: hit=%b data=%02h expected hit=%b data=%02h",
                  rq, a, bus_hit, bus_rdata, exp_hit, exp_data[7:0]);
      end
      @(posedge clk);
      if (rd_ok && lc >= 0) model_hi = model_mem[lc] / 256;
      if (cv) model_mem[ch] = d % 1024;
   endtask

   task automatic do_reset();
      @(negedge clk);
      cv_valid = 0; bus_rd = 0; bus_wr = 0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_hi = 0;
   endtask

   initial begin
      #(2 * HALF * 200000);
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R5 R2: latch reads zero after reset
      step(0, 0, 0, 'hF7, 1, 0, "R5");
      // R1: fill every channel
      for (int c = 0; c < 8; c++) step(1, c, 'h3A5 ^ (c * 'h91), 0, 0, 0, "R1");
      // R1 R9 R3 R2: read each low byte then the shared register
      for (int c = 0; c < 8; c++) begin
         step(0, 0, 0, 'h86 + 'h10 * c, 1, 0, "R1");
         step(0, 0, 0, 'hF7, 1, 0, "R3");
      end
      // R4: latch holds through conversions and other accesses
      step(0, 0, 0, 'hB6, 1, 0, "R3");
      step(1, 3, 'h0FF, 'hF7, 1, 0, "R4");
      step(1, 2, 'h2C3, 'h87, 1, 0, "R8");
      step(0, 0, 0, 'h55, 1, 0, "R8");
      step(0, 0, 0, 'hF7, 1, 0, "R4");
      step(0, 0, 0, 'hB6, 1, 0, "R3");
      step(0, 0, 0, 'hF7, 1, 0, "R4");
      // R6: conversion and read of the same channel in one cycle
      step(1, 5, 'h1E7, 'hD6, 1, 0, "R6");
      step(0, 0, 0, 'hF7, 1, 0, "R6");
      step(0, 0, 0, 'hD6, 1, 0, "R6");
      step(0, 0, 0, 'hF7, 1, 0, "R6");
      // R7: writes ignored, alone or together with a read
      step(0, 0, 0, 'h96, 0, 1, "R7");
      step(0, 0, 0, 'hF7, 0, 1, "R7");
      step(0, 0, 0, 'h96, 1, 1, "R7");
      step(0, 0, 0, 'hF7, 1, 0, "R7");
      step(0, 0, 0, 'h96, 1, 0, "R7");
      // R5: reset clears latch, keeps stored results
      do_reset();
      step(0, 0, 0, 'hF7, 1, 0, "R5");
      for (int c = 0; c < 8; c++) step(0, 0, 0, 'h86 + 'h10 * c, 1, 0, "R5");
      // Mixed traffic
      for (int k = 0; k < 400; k++) begin
         int pick = $urandom % 12;
         int a = (pick < 8) ? ('h86 + 'h10 * pick) : (pick == 8 ? 'hF7 : ($urandom % 256));
         step(($urandom % 2) == 1, $urandom % 8, $urandom % 1024, a,
              ($urandom % 4) != 0, ($urandom % 8) == 0, "R4");
      end
      step(0, 0, 0, 'hF7, 1, 0, "R2");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule